// File: doc/BRIEF.md
# Layered Tree-Search Candidate Expander

This block runs the tree search of a soft-output detector for four transmit and four receive streams carrying 64-QAM. It works on the real-valued form of the channel, which has eight real layers. Each layer carries one of the eight odd levels from -7 to +7. For each received vector the block takes an upper-triangular matrix `R` and the rotated received vector `y`, both in signed integer fixed point. It then produces a fixed set of 36 candidate symbol vectors, each with its accumulated squared-distance metric. A later stage turns these into bit reliabilities.

The search is deliberately narrow. The two top real layers, 7 and 6, are not searched. Their values come from a constant 6 x 6 grid of starting pairs. Every lower layer then keeps only one child: the level nearest to the estimate that remains after the already chosen symbols are cancelled.

Six candidate paths are evaluated side by side in each cycle. One vector therefore occupies the block for six cycles. A valid/ready handshake lets a new vector be taken in the last of those six cycles, so vectors can follow each other with no gap.

Top module: `tsx_expander`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A vector is taken on a rising edge where `in_valid` and `in_ready` are both 1. The signal `in_ready` is 0 during the first five output cycles of a vector. It is 1 in the sixth output cycle and whenever `out_valid` is 0.
- R3: Output starts in the cycle after a vector is taken. `out_valid` is then 1 for six consecutive cycles, with `out_base` stepping 0, 6, 12, 18, 24, 30. Path slot p of a cycle carries candidate `out_base + p`. `out_valid` returns to 0 afterwards unless another vector was taken.
- R4: For candidate k, layer 7 holds 2*(k/6)-5 and layer 6 holds 2*(k%6)-5, using integer division. The top two layers therefore never hold ±7.
- R5: For each layer i from 5 down to 0, let z = y[i] minus the sum over j>i of R[i][j]*s[j]. The symbol s[i] is the odd level in -7..+7 that minimises |z - R[i][i]*s|. On a tie the lower level is chosen, and outside the range the value saturates to ±7. The diagonal entries are assumed positive.
- R6: The metric of a candidate is the sum over all eight layers of e[i]^2, where e[i] = z[i] - R[i][i]*s[i].
- R7: A metric larger than 2^MW-1 is output as 2^MW-1, all ones.
- R8: Entries of `in_r` below the diagonal (i>j) have no effect on any output.
- R9: Encoding:
  - Entry R[i][j] sits at `in_r[(i*8+j)*RW +: RW]`, and y[i] sits at `in_y[i*YW +: YW]`. Both are two's complement.
  - Layer i of slot p is the 4-bit two's-complement field `out_sym[(p*8+i)*4 +: 4]`.
  - The metric of slot p is `out_metric[p*MW +: MW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new R matrix and received vector are offered |
| in_ready | output | 1 | The block takes the offered vector on this edge |
| in_r | input | 8*8*RW | R matrix, row-major, signed entries |
| in_y | input | 8*YW | Rotated received vector, signed |
| out_valid | output | 1 | Six candidates are presented this cycle |
| out_base | output | 6 | Candidate index of path slot 0 |
| out_sym | output | NPAR*8*4 | Symbol vectors of the six slots |
| out_metric | output | NPAR*MW | Saturating metrics of the six slots |

## Verification
Two things can happen in the same cycle: the last group of one vector is presented while the next vector is taken. The bench provokes this by offering vectors back to back. The block must then show candidates 30..35 of the old data, and in the very next cycle candidates 0..5 of the new data, with `in_ready` high only in that overlap cycle. Every candidate is compared in order against a back-substitution model that searches all levels by distance. Directed vectors cover exact ties, saturated symbols, saturated metrics and non-zero entries below the diagonal.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  localparam int NL    = 8;            // real layers
  localparam int SYMW  = 4;            // signed symbol width
  localparam int TOPN  = 6;            // levels per top layer in the start grid
  localparam int NCAND = TOPN * TOPN;  // candidates per vector
  localparam int CIW   = $clog2(NCAND);
  localparam int AW    = 48;           // internal arithmetic width

  // Start grid: upper layer walks slowly, lower layer walks fast.
  function automatic logic signed [SYMW-1:0] top_sym(input int k, input logic upper);
    int v;
    v = upper ? (2 * (k / TOPN) - (TOPN - 1)) : (2 * (k % TOPN) - (TOPN - 1));
    return SYMW'(v);
  endfunction

  // Nearest odd level: count thresholds d*2t passed, ties go low.
  function automatic logic signed [SYMW-1:0] near_level(input logic signed [AW-1:0] z,
                                                        input logic signed [AW-1:0] d);
    int cnt;
    logic signed [AW-1:0] th;
    cnt = 0;
    for (int t = -3; t <= 3; t++) begin
      th = d * AW'(2 * t);
      if (z > th) cnt++;
    end
    return SYMW'(2 * cnt - 7);
  endfunction
endpackage

// File: rtl/tsx_ctrl.sv
module tsx_ctrl #(
  parameter int NPH = 6,
  parameter int PW  = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          load,
  output logic          busy,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(NPH - 1);

  logic          busy_d;
  logic [PW-1:0] phase_d;

  assign in_ready = !busy || (phase == LAST);
  assign load     = in_valid && in_ready;

  always_comb begin
    busy_d  = busy;
    phase_d = phase;
    if (load) begin
      busy_d  = 1'b1;
      phase_d = '0;
    end else if (busy) begin
      if (phase == LAST) begin
        busy_d  = 1'b0;
        phase_d = '0;
      end else begin
        phase_d = phase + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else begin
      busy  <= busy_d;
      phase <= phase_d;
    end
  end
endmodule

// File: rtl/tsx_path.sv
module tsx_path
  import tsx_pkg::*;
#(
  parameter int RW = 12,
  parameter int YW = 16,
  parameter int MW = 32
) (
  input  logic [NL*NL*RW-1:0] r_flat,
  input  logic [NL*YW-1:0]    y_flat,
  input  logic [CIW-1:0]      cand,
  output logic [NL*SYMW-1:0]  sym_flat,
  output logic [MW-1:0]       metric
);
  localparam logic [63:0] MAXM = (64'd1 << MW) - 64'd1;

  logic signed [SYMW-1:0] sym [NL];
  logic signed [AW-1:0]   z, dg, rv, sv, e, sq;
  logic [63:0]            acc;

  always_comb begin
    sym      = '{default: '0};
    sym_flat = '0;
    acc      = '0;
    z = '0; dg = '0; rv = '0; sv = '0; e = '0; sq = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      z = {{(AW-YW){y_flat[i*YW+YW-1]}}, y_flat[i*YW +: YW]};
      for (int j = 0; j < NL; j++) begin
        if (j > i) begin
          rv = {{(AW-RW){r_flat[(i*NL+j)*RW+RW-1]}}, r_flat[(i*NL+j)*RW +: RW]};
          sv = {{(AW-SYMW){sym[j][SYMW-1]}}, sym[j]};
          z  = z - rv * sv;
        end
      end
      dg = {{(AW-RW){r_flat[(i*NL+i)*RW+RW-1]}}, r_flat[(i*NL+i)*RW +: RW]};
      if (i >= NL - 2) sym[i] = top_sym(int'(cand), 1'(i == NL - 1));
      else             sym[i] = near_level(z, dg);
      sv  = {{(AW-SYMW){sym[i][SYMW-1]}}, sym[i]};
      e   = z - dg * sv;
      sq  = e * e;
      acc = acc + {{(64-AW){1'b0}}, sq};
      sym_flat[i*SYMW +: SYMW] = sym[i];
    end
    metric = (acc > MAXM) ? '1 : acc[MW-1:0];
  end
endmodule

// File: rtl/tsx_expander.sv
module tsx_expander
  import tsx_pkg::*;
#(
  parameter int RW   = 12,
  parameter int YW   = 16,
  parameter int MW   = 32,
  parameter int NPAR = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NL*NL*RW-1:0]    in_r,
  input  logic [NL*YW-1:0]       in_y,
  output logic                   out_valid,
  output logic [CIW-1:0]         out_base,
  output logic [NPAR*NL*SYMW-1:0] out_sym,
  output logic [NPAR*MW-1:0]     out_metric
);
  localparam int NPH = NCAND / NPAR;
  localparam int PW  = (NPH > 1) ? $clog2(NPH) : 1;

  logic              load, busy;
  logic [PW-1:0]     phase;
  logic [NL*NL*RW-1:0] r_q;
  logic [NL*YW-1:0]    y_q;

  tsx_ctrl #(.NPH(NPH), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .busy(busy), .phase(phase)
  );

  always_ff @(posedge clk) begin
    if (load) begin
      r_q <= in_r;
      y_q <= in_y;
    end
  end

  assign out_valid = busy;
  assign out_base  = CIW'(int'(phase) * NPAR);

  for (genvar p = 0; p < NPAR; p++) begin : g_path
    logic [CIW-1:0] cidx;
    assign cidx = CIW'(int'(phase) * NPAR + p);
    tsx_path #(.RW(RW), .YW(YW), .MW(MW)) u_path (
      .r_flat(r_q), .y_flat(y_q), .cand(cidx),
      .sym_flat(out_sym[p*NL*SYMW +: NL*SYMW]),
      .metric(out_metric[p*MW +: MW])
    );
  end
endmodule

// File: rtl/tsx_expander_chk.sv
module tsx_expander_chk
  import tsx_pkg::*;
#(
  parameter int NPAR = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic [CIW-1:0]          out_base,
  input logic [NPAR*NL*SYMW-1:0] out_sym
);
  localparam logic [CIW-1:0] LASTB = CIW'(NCAND - NPAR);

  // R2: idle block always offers ready
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2: no new vector mid-run
  a_r2_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_base != LASTB) |-> !in_ready);

  // R3: first group follows acceptance
  a_r3_first_group: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_base == '0));

  // R3: groups step by NPAR
  a_r3_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_base != LASTB) |=>
      (out_valid && out_base == CIW'($past(out_base) + CIW'(NPAR))));

  // R3: stream stops after last group without new vector
  a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_base == LASTB && !(in_valid && in_ready)) |=> !out_valid);

  // R4, R5: symbols odd; top pair never at the outer levels
  always @(posedge clk) begin
    if (rst_n && out_valid) begin
      for (int p = 0; p < NPAR; p++) begin
        for (int i = 0; i < NL; i++) begin
          a_r5_odd_level: assert (out_sym[(p*NL+i)*SYMW] == 1'b1);
          if (i >= NL - 2) begin
            a_r4_top_inner: assert (out_sym[(p*NL+i)*SYMW +: SYMW] != 4'sd7 &&
                                    out_sym[(p*NL+i)*SYMW +: SYMW] != 4'b1001);
          end
        end
      end
    end
  end
endmodule

bind tsx_expander tsx_expander_chk #(.NPAR(NPAR)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_base(out_base), .out_sym(out_sym)
);

// File: tb/test_tsx_expander.sv
`timescale 1ns/1ps
module test_tsx_expander;
  localparam int RW = 12, YW = 16, MW = 32, NPAR = 6, NL = 8;
  localparam longint unsigned MAXM = (64'd1 << MW) - 64'd1;

  typedef struct packed {
    logic [5:0]    idx;
    logic          gb;
    logic [31:0]   sym;
    logic [MW-1:0] metric;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid;
  logic [NL*NL*RW-1:0] in_r = '0;
  logic [NL*YW-1:0]    in_y = '0;
  logic [5:0]          out_base;
  logic [NPAR*NL*4-1:0] out_sym;
  logic [NPAR*MW-1:0]  out_metric;

  int checks = 0, failures = 0;
  item_t q[$];

  always #4 clk = ~clk;

  tsx_expander #(.RW(RW), .YW(YW), .MW(MW), .NPAR(NPAR)) i_tsx_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_y(in_y), .out_valid(out_valid), .out_base(out_base),
    .out_sym(out_sym), .out_metric(out_metric)
  );

  function automatic longint rv(int i, int j);
    return longint'($signed(in_r[(i*NL+j)*RW +: RW]));
  endfunction
  function automatic longint yv(int i);
    return longint'($signed(in_y[i*YW +: YW]));
  endfunction
  function automatic longint absl(longint a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic set_r(int i, int j, int v);
    in_r[(i*NL+j)*RW +: RW] = v[RW-1:0];
  endtask
  task automatic set_y(int i, int v);
    in_y[i*YW +: YW] = v[YW-1:0];
  endtask

  // back-substitution model with exhaustive nearest-level search (R4..R7)
  task automatic push_expected(bit gb);
    int s[8];
    longint z, d, e, acc, bd;
    int best;
    item_t it;
    for (int k = 0; k < 36; k++) begin
      acc = 0;
      it = '0;
      for (int i = 7; i >= 0; i--) begin
        z = yv(i);
        for (int j = i + 1; j < 8; j++) z = z - rv(i, j) * longint'(s[j]);
        d = rv(i, i);
        if (i == 7) s[i] = 2 * (k / 6) - 5;
        else if (i == 6) s[i] = 2 * (k % 6) - 5;
        else begin
          best = -7;
          bd = absl(z + 7 * d);
          for (int v = -5; v <= 7; v += 2) begin
            if (absl(z - d * longint'(v)) < bd) begin
              best = v;
              bd = absl(z - d * longint'(v));
            end
          end
          s[i] = best;
        end
        e = z - d * longint'(s[i]);
        acc = acc + e * e;
        it.sym[i*4 +: 4] = s[i][3:0];
      end
      it.idx = 6'(k);
      it.gb = gb;
      it.metric = (longint'(acc) > longint'(MAXM)) ? '1 : acc[MW-1:0];
      q.push_back(it);
    end
  endtask

  task automatic send(bit gb);
    while (!in_ready) @(negedge clk);
    push_expected(gb);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rand_vec(bit gb);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (i == j) set_r(i, j, int'($urandom_range(255, 16)));
        else if (j > i) set_r(i, j, int'($urandom_range(256, 0)) - 128);
        else set_r(i, j, gb ? int'($urandom_range(4000, 0)) - 2000 : 0);
      end
      set_y(i, int'($urandom_range(8000, 0)) - 4000);
    end
  endtask

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(in_ready == (!out_valid || out_base == 6'd30), "R2 in_ready",
            longint'(in_ready), longint'(!out_valid || out_base == 6'd30));
        if (out_valid) begin
          for (int p = 0; p < NPAR; p++) begin
            if (q.size() == 0) begin
              chk(1'b0, "R3 unexpected output", longint'(out_base), -1);
            end else begin
              it = q.pop_front();
              chk(6'(out_base + p) == it.idx, "R3 candidate index",
                  longint'(out_base + p), longint'(it.idx));
              chk(out_sym[(p*8+6)*4 +: 8] == it.sym[31:24],
                  it.gb ? "R4 top pair (R8 lower garbage)" : "R4 top pair",
                  longint'(out_sym[(p*8+6)*4 +: 8]), longint'(it.sym[31:24]));
              chk(out_sym[p*32 +: 24] == it.sym[23:0],
                  it.gb ? "R5 R9 symbols (R8 lower garbage)" : "R5 R9 symbols",
                  longint'(out_sym[p*32 +: 24]), longint'(it.sym[23:0]));
              chk(out_metric[p*MW +: MW] == it.metric,
                  (it.metric == '1) ? "R7 saturated metric" : "R6 metric",
                  longint'(out_metric[p*MW +: MW]), longint'(it.metric));
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=stalled expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    // R5 ties: diagonal 4, no coupling, estimates on midpoints
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) set_r(i, j, (i == j) ? 4 : 0);
    end
    set_y(7, 10); set_y(6, -3);
    set_y(5, 8); set_y(4, -8); set_y(3, 12); set_y(2, 0); set_y(1, 4); set_y(0, -28);
    send(1'b0);

    // R5 symbol saturation and R7 metric saturation
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) set_r(i, j, (i == j) ? 2 : 0);
      set_y(i, (i % 2 == 0) ? 30000 : -30000);
    end
    send(1'b0);

    // back-to-back random vectors, some with garbage below diagonal (R8)
    for (int n = 0; n < 6; n++) begin
      rand_vec(n[0]);
      send(n[0]);
    end

    // idle gap, then one more vector
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R3 idle after stream", longint'(out_valid), 0);
    rand_vec(1'b1);
    send(1'b1);

    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R3 idle at end", longint'(out_valid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule